// File: doc/BRIEF.md
# Configuration Read Completion Status Handler

This block sits in a PCIe root port. On one side is the receiver that delivers completions from the link. On the other side is the requester that issued a configuration read. For each completion it receives:

- a 3-bit completion status code,
- 32-bit completion data,
- the register offset of the original request,
- the current software-visibility enable setting.

One cycle later it returns the final read data and status, an error flag, and a command/status-style acknowledge. A retry-status flag is raised alongside that acknowledge.

The block decides how a configuration retry completion is handled.

- When software visibility is enabled and the read targets the Vendor ID at offset 0, the retry becomes a visible read. It returns synthesized data holding an invalid Vendor ID, and its status is reported as success.
- In every other retry case, the read fails with all-ones data and the retry-status flag is raised.

Any other non-success completion also fails with all-ones data. The block never reissues a request; retry policy belongs to the requester upstream.

Top module: `cfg_cpl_status`

## Requirements
- R1: While reset is asserted, and until the internal reset release completes, `rsp_valid_o`, `cs_ack_o`, `cs_retry_o` and `rsp_err_o` are 0.
- R2: A completion with status 0 (success) returns its data unchanged with status 0, `rsp_err_o` = 0 and `cs_retry_o` = 0. This holds even when the data equals 0xFFFF0001.
- R3: A completion with status 2 (retry) and `sw_vis_en_i` = 1 whose offset is exactly 0 returns 0xFFFF0001: the low 16 bits are 0x0001 and the upper bits are all ones. Its status is reported as 0, with `rsp_err_o` = 0 and `cs_retry_o` = 0.
- R4: A completion with status 2 and `sw_vis_en_i` = 0 returns 0xFFFFFFFF with status 2, `rsp_err_o` = 1 and `cs_retry_o` = 1, for any offset including 0.
- R5: A completion with status 2 and `sw_vis_en_i` = 1 whose offset is not 0 returns 0xFFFFFFFF with status 2, `rsp_err_o` = 1 and `cs_retry_o` = 1.
- R6: A completion with any status other than 0 or 2 returns 0xFFFFFFFF. The received status is passed through, with `rsp_err_o` = 1 and `cs_retry_o` = 0. Examples are 1 (unsupported request) and 4 (completer abort).
- R7: Each accepted completion yields exactly one cycle of `rsp_valid_o`, in the clock cycle after `cpl_valid_i`. `cs_ack_o` equals `rsp_valid_o`, and `cs_retry_o` is never high without `cs_ack_o`. Back-to-back completions yield back-to-back responses.
- R8: The software-visible result is never reported with the retry status code (2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpl_valid_i | input | 1 | Completion present this cycle |
| cpl_status_i | input | 3 | Completion status code (0 success, 1 unsupported, 2 retry, 4 abort) |
| cpl_data_i | input | 32 | Completion data |
| req_offset_i | input | 12 | Register offset of the originating read |
| sw_vis_en_i | input | 1 | Software-visibility enable |
| rsp_valid_o | output | 1 | Final read result valid (one cycle) |
| rsp_data_o | output | 32 | Final read data |
| rsp_status_o | output | 3 | Final status code |
| rsp_err_o | output | 1 | Read failed |
| cs_ack_o | output | 1 | Command/status acknowledge |
| cs_retry_o | output | 1 | Retry status, high only with the acknowledge |

## Verification
The bench uses the default widths: 32-bit data, a 16-bit Vendor ID field, a 12-bit offset and a 3-bit status. These values let it drive all eight status codes and the extreme offsets 0x000, 0x001 and 0xFFF. They also allow success data equal to the synthesized pattern, so pass-through and synthesis must be distinguished by the inputs rather than by the data. A behavioural model predicts each response and is compared every cycle, over directed corner cases and a run of random back-to-back completions.

// File: rtl/cfg_cpl_pkg.sv
package cfg_cpl_pkg;
  typedef enum logic [1:0] {
    CLS_PASS       = 2'd0,
    CLS_SV_SYNTH   = 2'd1,
    CLS_RETRY_FAIL = 2'd2,
    CLS_ERR_FAIL   = 2'd3
  } cpl_class_e;
endpackage

// File: rtl/cfg_cpl_rst_sync.sv
module cfg_cpl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_cpl_classify.sv
module cfg_cpl_classify
  import cfg_cpl_pkg::*;
#(
  parameter int STAT_W     = 3,
  parameter int OFS_W      = 12,
  parameter int OK_CODE    = 0,
  parameter int RETRY_CODE = 2
) (
  input  logic [STAT_W-1:0] status_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic              sv_en_i,
  output cpl_class_e        class_o
);
  localparam logic [STAT_W-1:0] OK_V    = STAT_W'(OK_CODE);
  localparam logic [STAT_W-1:0] RETRY_V = STAT_W'(RETRY_CODE);

  logic is_ok, is_retry, at_vid;

  always_comb begin
    is_ok    = (status_i == OK_V);
    is_retry = (status_i == RETRY_V);
    at_vid   = (offset_i == '0);
    if (is_ok)                          class_o = CLS_PASS;
    else if (is_retry && sv_en_i && at_vid) class_o = CLS_SV_SYNTH;
    else if (is_retry)                  class_o = CLS_RETRY_FAIL;
    else                                class_o = CLS_ERR_FAIL;
  end
endmodule

// File: rtl/cfg_cpl_shape.sv
module cfg_cpl_shape
  import cfg_cpl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int STAT_W  = 3,
  parameter int VID_W   = 16,
  parameter int OK_CODE = 0
) (
  input  cpl_class_e        class_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [DATA_W-1:0] data_o,
  output logic [STAT_W-1:0] status_o,
  output logic              err_o,
  output logic              retry_o
);
  localparam logic [STAT_W-1:0] OK_V = STAT_W'(OK_CODE);

  logic [DATA_W-1:0] synth_word;

  generate
    if (DATA_W > VID_W) begin : g_wide
      assign synth_word = {{(DATA_W-VID_W){1'b1}}, VID_W'(1)};
    end else begin : g_narrow
      assign synth_word = DATA_W'(1);
    end
  endgenerate

  always_comb begin
    data_o   = '1;
    status_o = status_i;
    err_o    = 1'b1;
    retry_o  = 1'b0;
    case (class_i)
      CLS_PASS: begin
        data_o = data_i;
        err_o  = 1'b0;
      end
      CLS_SV_SYNTH: begin
        data_o   = synth_word;
        status_o = OK_V;
        err_o    = 1'b0;
      end
      CLS_RETRY_FAIL: begin
        retry_o = 1'b1;
      end
      default: begin
        retry_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/cfg_cpl_outreg.sv
module cfg_cpl_outreg #(
  parameter int DATA_W = 32,
  parameter int STAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic              err_i,
  input  logic              retry_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [STAT_W-1:0] status_o,
  output logic              err_o,
  output logic              retry_o
);
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              err_q, err_d;
  logic              retry_q, retry_d;

  always_comb begin
    valid_d = load_i;
    data_d  = data_q;
    stat_d  = stat_q;
    err_d   = 1'b0;
    retry_d = 1'b0;
    if (load_i) begin
      data_d  = data_i;
      stat_d  = status_i;
      err_d   = err_i;
      retry_d = retry_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      stat_q  <= '0;
      err_q   <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      stat_q  <= stat_d;
      err_q   <= err_d;
      retry_q <= retry_d;
    end
  end

  assign valid_o  = valid_q;
  assign data_o   = data_q;
  assign status_o = stat_q;
  assign err_o    = err_q;
  assign retry_o  = retry_q;
endmodule

// File: rtl/cfg_cpl_status.sv
module cfg_cpl_status
  import cfg_cpl_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int STAT_W     = 3,
  parameter int OFS_W      = 12,
  parameter int VID_W      = 16,
  parameter int OK_CODE    = 0,
  parameter int RETRY_CODE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpl_valid_i,
  input  logic [STAT_W-1:0] cpl_status_i,
  input  logic [DATA_W-1:0] cpl_data_i,
  input  logic [OFS_W-1:0]  req_offset_i,
  input  logic              sw_vis_en_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [STAT_W-1:0] rsp_status_o,
  output logic              rsp_err_o,
  output logic              cs_ack_o,
  output logic              cs_retry_o
);
  localparam logic [STAT_W-1:0] OK_V    = STAT_W'(OK_CODE);
  localparam logic [STAT_W-1:0] RETRY_V = STAT_W'(RETRY_CODE);

  logic              rst_sync_n;
  cpl_class_e        cls;
  logic [DATA_W-1:0] shp_data;
  logic [STAT_W-1:0] shp_stat;
  logic              shp_err, shp_retry;

  cfg_cpl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cfg_cpl_classify #(
    .STAT_W(STAT_W), .OFS_W(OFS_W), .OK_CODE(OK_CODE), .RETRY_CODE(RETRY_CODE)
  ) u_cls (
    .status_i(cpl_status_i), .offset_i(req_offset_i), .sv_en_i(sw_vis_en_i),
    .class_o(cls)
  );

  cfg_cpl_shape #(
    .DATA_W(DATA_W), .STAT_W(STAT_W), .VID_W(VID_W), .OK_CODE(OK_CODE)
  ) u_shp (
    .class_i(cls), .data_i(cpl_data_i), .status_i(cpl_status_i),
    .data_o(shp_data), .status_o(shp_stat), .err_o(shp_err), .retry_o(shp_retry)
  );

  cfg_cpl_outreg #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_out (
    .clk(clk), .rst_n(rst_sync_n), .load_i(cpl_valid_i),
    .data_i(shp_data), .status_i(shp_stat), .err_i(shp_err), .retry_i(shp_retry),
    .valid_o(rsp_valid_o), .data_o(rsp_data_o), .status_o(rsp_status_o),
    .err_o(rsp_err_o), .retry_o(cs_retry_o)
  );

  assign cs_ack_o = rsp_valid_o;

  // Checker support: becomes 1 one cycle after internal reset release
  logic chk_armed;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) chk_armed <= 1'b0;
    else             chk_armed <= 1'b1;
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_sync_n |=> (!rsp_valid_o || !rst_sync_n));

  a_r7_valid_tracks_input: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chk_armed |-> (rsp_valid_o == $past(cpl_valid_i)));

  a_r7_retry_only_with_ack: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cs_retry_o |-> (cs_ack_o && rsp_valid_o));

  a_r2_success_passes: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chk_armed && $past(cpl_valid_i && cpl_status_i == OK_V)) |->
      (rsp_data_o == $past(cpl_data_i) && !rsp_err_o && !cs_retry_o));

  a_r3_visible_synth: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chk_armed && $past(cpl_valid_i && cpl_status_i == RETRY_V && sw_vis_en_i
                        && req_offset_i == '0)) |->
      (!cs_retry_o && !rsp_err_o && rsp_data_o[VID_W-1:0] == VID_W'(1)));

  a_r8_visible_not_retry_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid_o && !rsp_err_o) |-> (rsp_status_o != RETRY_V));

  a_r4_hidden_retry_fails: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chk_armed && $past(cpl_valid_i && cpl_status_i == RETRY_V && !sw_vis_en_i)) |->
      (cs_retry_o && rsp_err_o && rsp_data_o == '1));

  a_r5_nonzero_offset_fails: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chk_armed && $past(cpl_valid_i && cpl_status_i == RETRY_V && req_offset_i != '0)) |->
      (cs_retry_o && rsp_data_o == '1));

  a_r6_other_error: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chk_armed && $past(cpl_valid_i && cpl_status_i != OK_V && cpl_status_i != RETRY_V)) |->
      (!cs_retry_o && rsp_err_o && rsp_data_o == '1
       && rsp_status_o == $past(cpl_status_i)));
endmodule

// File: tb/test_cfg_cpl_status.sv
module test_cfg_cpl_status;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpl_valid_i;
  logic [2:0]  cpl_status_i;
  logic [31:0] cpl_data_i;
  logic [11:0] req_offset_i;
  logic        sw_vis_en_i;
  logic        rsp_valid_o;
  logic [31:0] rsp_data_o;
  logic [2:0]  rsp_status_o;
  logic        rsp_err_o, cs_ack_o, cs_retry_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // expected response for the completion driven in the previous cycle
  bit          e_valid;
  logic [31:0] e_data;
  logic [2:0]  e_stat;
  bit          e_err, e_retry;
  string       e_req;

  always #2 clk = ~clk;

  cfg_cpl_status i_cfg_cpl_status (
    .clk(clk), .rst_n(rst_n), .cpl_valid_i(cpl_valid_i), .cpl_status_i(cpl_status_i),
    .cpl_data_i(cpl_data_i), .req_offset_i(req_offset_i), .sw_vis_en_i(sw_vis_en_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o), .rsp_status_o(rsp_status_o),
    .rsp_err_o(rsp_err_o), .cs_ack_o(cs_ack_o), .cs_retry_o(cs_retry_o)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R7", "valid", rsp_valid_o, e_valid);
    chk("R7", "ack", cs_ack_o, e_valid);
    if (e_valid) begin
      chk(e_req, "data", rsp_data_o, e_data);
      chk(e_req, "status", rsp_status_o, e_stat);
      chk(e_req, "err", rsp_err_o, e_err);
      chk(e_req, "retry", cs_retry_o, e_retry);
      if (!e_err) chk("R8", "status not retry", rsp_status_o == 3'd2, 0);
    end else begin
      chk("R7", "retry idle", cs_retry_o, 0);
    end
  endtask

  // behavioural model of the requirements
  task automatic model(bit v, logic [2:0] st, logic [31:0] d, logic [11:0] ofs, bit sv);
    e_valid = v;
    e_retry = 0;
    if (st == 3'd0) begin
      e_data = d; e_stat = 3'd0; e_err = 0; e_req = "R2";
    end else if (st == 3'd2 && sv && ofs == 12'd0) begin
      e_data = 32'hFFFF_0001; e_stat = 3'd0; e_err = 0; e_req = "R3";
    end else if (st == 3'd2) begin
      e_data = 32'hFFFF_FFFF; e_stat = 3'd2; e_err = 1; e_retry = 1;
      e_req = sv ? "R5" : "R4";
    end else begin
      e_data = 32'hFFFF_FFFF; e_stat = st; e_err = 1; e_req = "R6";
    end
  endtask

  task automatic step(bit v, logic [2:0] st, logic [31:0] d, logic [11:0] ofs, bit sv);
    @(negedge clk);
    compare();
    cpl_valid_i = v; cpl_status_i = st; cpl_data_i = d;
    req_offset_i = ofs; sw_vis_en_i = sv;
    model(v, st, d, ofs, sv);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cpl_valid_i = 0; cpl_status_i = 0; cpl_data_i = 0; req_offset_i = 0; sw_vis_en_i = 0;
    e_valid = 0; e_data = 0; e_stat = 0; e_err = 0; e_retry = 0; e_req = "R1";
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", rsp_valid_o, 0);
    chk("R1", "ack in reset", cs_ack_o, 0);
    chk("R1", "retry in reset", cs_retry_o, 0);
    chk("R1", "err in reset", rsp_err_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "valid during release", rsp_valid_o, 0);
    repeat (2) @(negedge clk);

    // R2 pass-through, including the synthesized pattern as real data
    step(1, 3'd0, 32'h1234_5678, 12'h000, 1);
    step(1, 3'd0, 32'hFFFF_0001, 12'h000, 1);
    step(1, 3'd0, 32'hFFFF_0001, 12'h004, 0);
    // R3 visible synthesis
    step(1, 3'd2, 32'h0000_0000, 12'h000, 1);
    step(0, 3'd0, 32'h0, 12'h0, 0);
    // R4 hidden retry, offset 0 and non-zero
    step(1, 3'd2, 32'hDEAD_BEEF, 12'h000, 0);
    step(1, 3'd2, 32'h0000_0001, 12'h008, 0);
    // R5 enabled but offset not 0
    step(1, 3'd2, 32'h0, 12'h001, 1);
    step(1, 3'd2, 32'h0, 12'h004, 1);
    step(1, 3'd2, 32'h0, 12'hFFF, 1);
    // R6 other errors
    step(1, 3'd1, 32'hAAAA_5555, 12'h000, 1);
    step(1, 3'd4, 32'h0, 12'h000, 1);
    for (int s = 0; s < 8; s++) step(1, 3'(s), 32'h0BAD_F00D, 12'h000, 1);
    step(0, 3'd2, 32'h0, 12'h0, 1);
    step(0, 3'd0, 32'h0, 12'h0, 0);
    // random back-to-back traffic
    for (int i = 0; i < 600; i++) begin
      logic [11:0] o;
      o = ($urandom % 4 == 0) ? 12'h000 : 12'($urandom);
      step(1'($urandom % 4 != 0), 3'($urandom), $urandom, o, 1'($urandom));
    end
    step(0, 3'd0, 32'h0, 12'h0, 0);
    step(0, 3'd0, 32'h0, 12'h0, 0);
    done = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule